// File: doc/BRIEF.md
# Back-to-Back Instruction Dependency Checker

This block compares two neighbouring instructions: the one that is about to retire (the "older" one) and the one that follows it (the "younger" one). From the operand descriptors of both it decides, in a single combinational step, whether the younger instruction depends on the older one. A pipeline can use this bit to insert a hazard stall, or to refuse to issue the pair together.

Each descriptor is already decoded. The older instruction gives the kind of its destination and the destination register number, and says whether it writes the condition flag. The younger instruction gives a configurable number of source slots, each with a kind and a register number. It also gives its own destination kind and register, and says whether it reads the condition flag. The rules depend on the addressing mode of each operand. A memory-form destination of the younger instruction (a store) has a base register that is read, so that base is checked as a base-register source.

Top module: `pair_hazard_detect`

## Requirements
- R1: When the older instruction writes the condition flag and the younger reads it, `dep_o` is 1, whatever the operands are.
- R2: A destination kind of 2'b00 (none) or 2'b01 (reserved) on the older instruction never causes a dependency. Only the flag rule of R1 can then raise `dep_o`.
- R3: A source slot of kind 2'b00 (unused) or 2'b01 (immediate) never contributes to a dependency, whatever its register field holds.
- R4: An older destination of kind 2'b10 (register direct) and a younger source of kind 2'b10 (register direct) with equal register numbers give `dep_o` = 1.
- R5: An older direct destination and a younger direct or base source with different register numbers give no dependency.
- R6: An older destination of kind 2'b11 (memory form, a store) never conflicts with a younger direct source, even when the register numbers are equal.
- R7: An older direct destination and a younger source of kind 2'b11 (used as a displacement base) with equal register numbers give `dep_o` = 1.
- R8: An older memory-form destination and any younger memory-form operand give `dep_o` = 1 whatever the register numbers are. A store must complete before a later memory access.
- R9: When the younger destination kind is 2'b11, its register number is a base read and is checked as a base source under R7 and R8. A younger destination of kind 2'b10 is only written and never causes a dependency.
- R10: `dep_o` is a purely combinational function of the current inputs and is valid in the same cycle, with no register on the path.
- R11: Every source slot takes part, including the highest-numbered one. Slot k sits at bits [2k+1:2k] of the kind vector and at bits [REG_W*(k+1)-1:REG_W*k] of the register vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| old_dst_kind_i | input | 2 | Destination kind of the older instruction: 00 none, 01 reserved, 10 direct, 11 memory form |
| old_dst_reg_i | input | REG_W | Destination (or base) register number of the older instruction |
| old_flag_wr_i | input | 1 | Older instruction writes the condition flag |
| new_src_kind_i | input | 2*N_SRC | Source slot kinds: 00 unused, 01 immediate, 10 direct, 11 base |
| new_src_reg_i | input | REG_W*N_SRC | Source slot register numbers |
| new_dst_kind_i | input | 2 | Destination kind of the younger instruction |
| new_dst_reg_i | input | REG_W | Destination (or base) register number of the younger instruction |
| new_flag_rd_i | input | 1 | Younger instruction reads the condition flag |
| dep_o | output | 1 | Younger instruction depends on the older one |

## Verification
Directed pairs place the same register number under each combination of older destination kind and younger operand kind. This separates a true register match from one that the addressing mode masks, such as an immediate, or a store followed by a direct read. Pairs that differ only in the register number separate number matching from the unconditional memory ordering rule. Other pairs put the store base into the younger destination field, or put the operand in the last slot, to expose an operand that is left out. Pseudo-random descriptors are then compared on every clock against a behavioural model. A change of inputs between clock edges shows that the result does not wait for a clock.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    localparam int unsigned REG_W_DEF = 5;
    localparam int unsigned N_SRC_DEF = 3;

    typedef enum logic [1:0] {
        SRC_UNUSED = 2'b00,
        SRC_IMM    = 2'b01,
        SRC_DIRECT = 2'b10,
        SRC_BASE   = 2'b11
    } src_kind_e;

    typedef enum logic [1:0] {
        DST_NONE   = 2'b00,
        DST_RSVD   = 2'b01,
        DST_DIRECT = 2'b10,
        DST_MEM    = 2'b11
    } dst_kind_e;

    // Decoded view of the older instruction's destination
    typedef struct packed {
        logic writes_reg;   // direct register write
        logic mem_form;     // displacement (store) destination
    } old_view_t;

    function automatic old_view_t decode_old(dst_kind_e k);
        old_view_t v;
        v.writes_reg = (k == DST_DIRECT);
        v.mem_form   = (k == DST_MEM);
        return v;
    endfunction

    // Kind a younger destination presents when treated as an operand
    function automatic src_kind_e dst_as_operand(dst_kind_e k);
        return (k == DST_MEM) ? SRC_BASE : SRC_UNUSED;
    endfunction

endpackage

// File: rtl/hpc_operand_cmp.sv
module hpc_operand_cmp
    import hpc_pkg::*;
#(
    parameter int unsigned REG_W = REG_W_DEF
) (
    input  old_view_t          old_v,
    input  logic [REG_W-1:0]   old_reg,
    input  src_kind_e          op_kind,
    input  logic [REG_W-1:0]   op_reg,
    output logic               hit
);
    logic same_reg;
    logic op_direct;
    logic op_base;

    always_comb begin
        same_reg  = (old_reg == op_reg);
        op_direct = (op_kind == SRC_DIRECT);
        op_base   = (op_kind == SRC_BASE);
        hit = 1'b0;
        if (old_v.writes_reg && (op_direct || op_base) && same_reg)
            hit = 1'b1;
        if (old_v.mem_form && op_base)
            hit = 1'b1;
    end
endmodule

// File: rtl/hpc_merge.sv
module hpc_merge #(
    parameter int unsigned N_OPS = 4
) (
    input  logic [N_OPS-1:0] op_hits,
    input  logic             flag_wr,
    input  logic             flag_rd,
    output logic             dep
);
    always_comb begin
        dep = flag_wr & flag_rd;
        for (int i = 0; i < int'(N_OPS); i++)
            dep = dep | op_hits[i];
    end
endmodule

// File: rtl/pair_hazard_detect.sv
module pair_hazard_detect
    import hpc_pkg::*;
#(
    parameter int unsigned REG_W = REG_W_DEF,
    parameter int unsigned N_SRC = N_SRC_DEF
) (
    input  logic [1:0]             old_dst_kind_i,
    input  logic [REG_W-1:0]       old_dst_reg_i,
    input  logic                   old_flag_wr_i,
    input  logic [2*N_SRC-1:0]     new_src_kind_i,
    input  logic [REG_W*N_SRC-1:0] new_src_reg_i,
    input  logic [1:0]             new_dst_kind_i,
    input  logic [REG_W-1:0]       new_dst_reg_i,
    input  logic                   new_flag_rd_i,
    output logic                   dep_o
);
    localparam int unsigned N_OPS = N_SRC + 1;

    old_view_t         old_v;
    src_kind_e         op_kind [N_OPS];
    logic [REG_W-1:0]  op_reg  [N_OPS];
    logic [N_OPS-1:0]  op_hits;

    assign old_v = decode_old(dst_kind_e'(old_dst_kind_i));

    genvar g;
    generate
        for (g = 0; g < int'(N_OPS); g++) begin : g_op
            if (g < int'(N_SRC)) begin : g_src
                assign op_kind[g] = src_kind_e'(new_src_kind_i[2*g +: 2]);
                assign op_reg[g]  = new_src_reg_i[REG_W*g +: REG_W];
            end else begin : g_store_base
                assign op_kind[g] = dst_as_operand(dst_kind_e'(new_dst_kind_i));
                assign op_reg[g]  = new_dst_reg_i;
            end
            hpc_operand_cmp #(.REG_W(REG_W)) u_cmp (
                .old_v   (old_v),
                .old_reg (old_dst_reg_i),
                .op_kind (op_kind[g]),
                .op_reg  (op_reg[g]),
                .hit     (op_hits[g])
            );
        end
    endgenerate

    hpc_merge #(.N_OPS(N_OPS)) u_merge (
        .op_hits (op_hits),
        .flag_wr (old_flag_wr_i),
        .flag_rd (new_flag_rd_i),
        .dep     (dep_o)
    );
endmodule

// File: rtl/pair_hazard_detect_chk.sv
module pair_hazard_detect_chk #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned N_SRC = 3
) (
    input logic [1:0]             old_dst_kind_i,
    input logic [REG_W-1:0]       old_dst_reg_i,
    input logic                   old_flag_wr_i,
    input logic [2*N_SRC-1:0]     new_src_kind_i,
    input logic [REG_W*N_SRC-1:0] new_src_reg_i,
    input logic [1:0]             new_dst_kind_i,
    input logic [REG_W-1:0]       new_dst_reg_i,
    input logic                   new_flag_rd_i,
    input logic                   dep_o
);
    logic flag_pair;
    logic any_reg_read;
    logic any_mem_op;
    logic direct_match;
    logic base_match;

    always_comb begin
        flag_pair    = old_flag_wr_i && new_flag_rd_i;
        any_reg_read = (new_dst_kind_i == 2'b11);
        any_mem_op   = (new_dst_kind_i == 2'b11);
        direct_match = 1'b0;
        base_match   = (new_dst_kind_i == 2'b11) && (new_dst_reg_i == old_dst_reg_i);
        for (int k = 0; k < int'(N_SRC); k++) begin
            if (new_src_kind_i[2*k+1])
                any_reg_read = 1'b1;
            if (new_src_kind_i[2*k +: 2] == 2'b11) begin
                any_mem_op = 1'b1;
                if (new_src_reg_i[REG_W*k +: REG_W] == old_dst_reg_i)
                    base_match = 1'b1;
            end
            if ((new_src_kind_i[2*k +: 2] == 2'b10) &&
                (new_src_reg_i[REG_W*k +: REG_W] == old_dst_reg_i))
                direct_match = 1'b1;
        end

        if (flag_pair)
            assert_flag_raw_R1: assert (dep_o) else $error("flag pair without dependency");
        if (!old_dst_kind_i[1] && !flag_pair)
            assert_no_dst_quiet_R2: assert (!dep_o) else $error("dependency without older destination");
        if (!any_reg_read && !flag_pair)
            assert_imm_quiet_R3: assert (!dep_o) else $error("dependency with no register operand");
        if (old_dst_kind_i == 2'b10 && direct_match)
            assert_direct_match_R4: assert (dep_o) else $error("direct match missed");
        if (old_dst_kind_i == 2'b11 && !any_mem_op && !flag_pair)
            assert_store_vs_direct_R6: assert (!dep_o) else $error("store against direct source flagged");
        if (old_dst_kind_i == 2'b10 && base_match)
            assert_base_match_R7: assert (dep_o) else $error("base register match missed");
        if (old_dst_kind_i == 2'b11 && any_mem_op)
            assert_mem_order_R8: assert (dep_o) else $error("memory ordering missed");
    end
endmodule

bind pair_hazard_detect pair_hazard_detect_chk #(.REG_W(REG_W), .N_SRC(N_SRC)) u_chk (
    .old_dst_kind_i (old_dst_kind_i),
    .old_dst_reg_i  (old_dst_reg_i),
    .old_flag_wr_i  (old_flag_wr_i),
    .new_src_kind_i (new_src_kind_i),
    .new_src_reg_i  (new_src_reg_i),
    .new_dst_kind_i (new_dst_kind_i),
    .new_dst_reg_i  (new_dst_reg_i),
    .new_flag_rd_i  (new_flag_rd_i),
    .dep_o          (dep_o)
);

// File: tb/test_pair_hazard_detect.sv
module test_pair_hazard_detect;
    localparam int RW = 5;
    localparam int NS = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      odk;
    logic [RW-1:0]   odr;
    logic            ofw;
    logic [2*NS-1:0] nsk;
    logic [RW*NS-1:0] nsr;
    logic [1:0]      ndk;
    logic [RW-1:0]   ndr;
    logic            nfr;
    logic            dep;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pair_hazard_detect #(.REG_W(RW), .N_SRC(NS)) i_pair_hazard_detect (
        .old_dst_kind_i (odk), .old_dst_reg_i (odr), .old_flag_wr_i (ofw),
        .new_src_kind_i (nsk), .new_src_reg_i (nsr),
        .new_dst_kind_i (ndk), .new_dst_reg_i (ndr), .new_flag_rd_i (nfr),
        .dep_o (dep)
    );

    // Behavioural model built from the requirement list
    function automatic bit model();
        int kinds [$];
        int regs  [$];
        if (ofw && nfr) return 1'b1;
        if (odk != 2'b10 && odk != 2'b11) return 1'b0;
        for (int k = 0; k < NS; k++) begin
            kinds.push_back(int'(nsk[2*k +: 2]));
            regs.push_back(int'(nsr[RW*k +: RW]));
        end
        if (ndk == 2'b11) begin
            kinds.push_back(3);
            regs.push_back(int'(ndr));
        end
        foreach (kinds[i]) begin
            if (kinds[i] == 2 && odk == 2'b10 && regs[i] == int'(odr)) return 1'b1;
            if (kinds[i] == 3 && odk == 2'b11) return 1'b1;
            if (kinds[i] == 3 && odk == 2'b10 && regs[i] == int'(odr)) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check(string tag, bit exp);
        checks++;
        if (dep !== exp) begin
            fails++;
            $display("FAIL %s dep_o actual=%b expected=%b", tag, dep, exp);
        end
    endtask

    task automatic clear();
        odk = 2'b00; odr = '0; ofw = 1'b0;
        nsk = '0; nsr = '0; ndk = 2'b00; ndr = '0; nfr = 1'b0;
    endtask

    task automatic set_src(int k, logic [1:0] kind, logic [RW-1:0] r);
        nsk[2*k +: 2]   = kind;
        nsr[RW*k +: RW] = r;
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    initial begin
        clear();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        settle(); check("R2 reset state", 1'b0);

        clear(); ofw = 1; nfr = 1; settle(); check("R1 flag raw no dst", 1'b1);
        clear(); ofw = 1; nfr = 0; odk = 2'b10; odr = 5; settle(); check("R1 write without read", 1'b0);
        clear(); odk = 2'b10; odr = 5; set_src(0, 2'b01, 5); set_src(1, 2'b00, 5);
        settle(); check("R3 immediate slot", 1'b0);
        clear(); odk = 2'b10; odr = 5; set_src(0, 2'b10, 5); settle(); check("R4 direct match", 1'b1);
        clear(); odk = 2'b10; odr = 5; set_src(0, 2'b10, 6); set_src(1, 2'b11, 4);
        settle(); check("R5 unequal numbers", 1'b0);
        clear(); odk = 2'b11; odr = 5; set_src(0, 2'b10, 5); settle(); check("R6 store vs direct", 1'b0);
        clear(); odk = 2'b10; odr = 5; set_src(1, 2'b11, 5); settle(); check("R7 base match", 1'b1);
        clear(); odk = 2'b11; odr = 5; set_src(2, 2'b11, 9); settle(); check("R8 store then load", 1'b1);
        clear(); odk = 2'b10; odr = 5; ndk = 2'b11; ndr = 5; settle(); check("R9 store base read", 1'b1);
        clear(); odk = 2'b10; odr = 5; ndk = 2'b10; ndr = 5; settle(); check("R9 direct write only", 1'b0);
        clear(); odk = 2'b11; odr = 5; ndk = 2'b11; ndr = 7; settle(); check("R9 store then store", 1'b1);
        clear(); odk = 2'b10; odr = 5; set_src(NS-1, 2'b10, 5); settle(); check("R11 last slot", 1'b1);
        clear(); odk = 2'b01; odr = 5; set_src(0, 2'b10, 5); set_src(1, 2'b11, 5);
        settle(); check("R2 reserved kind", 1'b0);

        // R10: change inputs mid-cycle and read back without a clock edge
        clear(); odk = 2'b10; odr = 3; set_src(0, 2'b10, 3); settle();
        #1 set_src(0, 2'b10, 4); #1 check("R10 same cycle drop", 1'b0);
        #1 set_src(0, 2'b11, 3); #1 check("R10 same cycle rise", 1'b1);

        // Pseudo-random descriptors against the model on every clock
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            odk = 2'($urandom);
            odr = RW'($urandom_range(0, 7));
            ofw = 1'($urandom);
            nsk = (2*NS)'($urandom);
            for (int k = 0; k < NS; k++)
                nsr[RW*k +: RW] = RW'($urandom_range(0, 7));
            ndk = 2'($urandom);
            ndr = RW'($urandom_range(0, 7));
            nfr = 1'($urandom);
            #2 check("R10 random pair", model());
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule